// File: doc/BRIEF.md
# ALU with Operation Decode

This block is the arithmetic and logic unit of a small load/store processor, packaged with the two-level logic that picks its operation. The main controller supplies a 2-bit class code. Two of the class values fix the operation directly: one selects add, for address and increment arithmetic, and the other selects subtract, for equality tests. A third class value tells the block to read the 6-bit function field of a register-type instruction instead. The decoder turns this pair of inputs into a 3-bit operation select. That select is exported and also drives the datapath.

The datapath takes two 32-bit operands. It performs bitwise AND, bitwise OR, add, subtract, or a signed set-on-less-than. Alongside the 32-bit result it reports a zero flag and a signed overflow flag. The zero flag is what a branch-on-equal uses after a subtract. The whole block is combinational: every output follows its inputs within the same cycle, and the block holds no state.

Top module: `alu_with_decode`

## Requirements
- R1: The operation select takes only these codes: 3'b000 bitwise AND, 3'b001 bitwise OR, 3'b010 add, 3'b110 subtract, 3'b111 signed set-on-less-than.
- R2: Class code 2'b00 selects add, whatever the function field holds.
- R3: Class code 2'b01 selects subtract, whatever the function field holds.
- R4: With class code 2'b10, the function field selects the operation: 6'b100000 add, 6'b100010 subtract, 6'b100100 AND, 6'b100101 OR, 6'b101010 set-on-less-than.
- R5: Class code 2'b11 selects add. With class 2'b10, any function value other than the five listed also selects add.
- R6: AND and OR produce the bitwise combination of the two operands.
- R7: Add produces A+B modulo 2^32, and subtract produces A-B modulo 2^32.
- R8: Set-on-less-than treats both operands as two's-complement numbers. Its result is 1 when A is less than B and 0 otherwise, and bits 31..1 are always 0.
- R9: The zero output is 1 exactly when all 32 result bits are 0.
- R10: The overflow output is 1 only for add or subtract whose true signed result lies outside the 32-bit two's-complement range. It is 0 for AND, OR and set-on-less-than.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cls_code | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of a register-type instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_op | output | 3 | Decoded operation select |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
All four outputs are combinational, so each one is due in the same cycle that its inputs are applied, with no register on the way. The bench applies each input set just after a rising clock edge. It samples the operation select, the result, the zero flag and the overflow flag at the following falling edge, half a period later. By then the inputs have been stable long enough for the outputs to settle. The next input set is applied only after those samples have been taken.

// File: rtl/alu_pkg.sv
// Package: shared operation codes, class codes and function-field values
// for the ALU and its decoder. Assumes the 3-bit select and the 6-bit
// function field are fixed by the instruction format.
package alu_pkg;
    localparam int OP_W    = 3;
    localparam int FUNCT_W = 6;
    localparam int CLS_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    localparam logic [CLS_W-1:0] CLS_FORCE_ADD = 2'b00;
    localparam logic [CLS_W-1:0] CLS_FORCE_SUB = 2'b01;
    localparam logic [CLS_W-1:0] CLS_BY_FUNCT  = 2'b10;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_op_decode.sv
// Module: alu_op_decode
// Maps a controller class code and an instruction function field to an
// ALU operation. Two class values fix the operation. The third defers to
// the function field. Everything that is not listed falls back to add.
// Assumes: purely combinational, no state.
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [CLS_W-1:0]   cls_code,
    input  logic [FUNCT_W-1:0] funct,
    output alu_op_e            op_sel
);
    // Second level: function field to operation.
    alu_op_e funct_op;
    always_comb begin
        case (funct)
            FN_SUB:  funct_op = OP_SUB;
            FN_AND:  funct_op = OP_AND;
            FN_OR:   funct_op = OP_OR;
            FN_SLT:  funct_op = OP_SLT;
            default: funct_op = OP_ADD;
        endcase
    end

    // First level: the class code either forces an operation or defers.
    always_comb begin
        case (cls_code)
            CLS_FORCE_SUB: op_sel = OP_SUB;
            CLS_BY_FUNCT:  op_sel = funct_op;
            default:       op_sel = OP_ADD;
        endcase
    end

    // The select must always be one of the five defined codes.
    always_comb begin
        if (!$isunknown({cls_code, funct})) begin
            assert_op_legal_R1: assert (op_sel inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT})
                else $error("operation select outside the defined set");
        end
    end
endmodule

// File: rtl/alu_addsub.sv
// Module: alu_addsub
// Shared adder for add, subtract and signed compare. When sub is high, B
// is inverted and a carry-in of 1 is added. Also reports signed overflow
// and the signed less-than outcome of A-B.
// Assumes: two's-complement operands, combinational only.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         lt
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;

    // Condition B for subtraction and form the sum.
    always_comb begin
        b_eff = b ^ {W{sub}};
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    end

    // Overflow: both addends share a sign that the sum does not.
    // Less-than: the sign of the exact difference.
    always_comb begin
        ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        lt  = sum[MSB] ^ ovf;
    end
endmodule

// File: rtl/alu_logic_unit.sv
// Module: alu_logic_unit
// Bitwise AND and OR of the two operands, built one bit slice at a time.
// Assumes: combinational only.
module alu_logic_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_v,
    output logic [W-1:0] or_v
);
    // One slice per bit: both gates side by side.
    for (genvar i = 0; i < W; i++) begin : g_slice
        assign and_v[i] = a[i] & b[i];
        assign or_v[i]  = a[i] | b[i];
    end
endmodule

// File: rtl/alu_with_decode.sv
// Module: alu_with_decode
// Top of the ALU. Decodes the class code and function field into an
// operation, runs the operands through the shared adder and the logic
// unit, picks the result, and derives the zero and overflow flags.
// Assumes: combinational only; the host registers what it needs.
module alu_with_decode
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        cls_code,
    input  logic [5:0]        funct,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [2:0]        alu_op,
    output logic [DATA_W-1:0] result,
    output logic              zero,
    output logic              ovf
);
    alu_op_e            op_sel;
    logic               use_sub;
    logic [DATA_W-1:0]  sum_v;
    logic [DATA_W-1:0]  and_v;
    logic [DATA_W-1:0]  or_v;
    logic               add_ovf;
    logic               less;

    alu_op_decode u_decode (
        .cls_code (cls_code),
        .funct    (funct),
        .op_sel   (op_sel)
    );

    // Subtract and compare both need A-B.
    always_comb use_sub = (op_sel == OP_SUB) || (op_sel == OP_SLT);

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a   (opnd_a),
        .b   (opnd_b),
        .sub (use_sub),
        .sum (sum_v),
        .ovf (add_ovf),
        .lt  (less)
    );

    alu_logic_unit #(.W(DATA_W)) u_logic (
        .a     (opnd_a),
        .b     (opnd_b),
        .and_v (and_v),
        .or_v  (or_v)
    );

    // Pick the result for the decoded operation.
    always_comb begin
        case (op_sel)
            OP_AND:  result = and_v;
            OP_OR:   result = or_v;
            OP_SLT:  result = {{(DATA_W-1){1'b0}}, less};
            default: result = sum_v;
        endcase
    end

    // Flags: zero from the result; overflow only for add and subtract.
    always_comb begin
        zero   = ~|result;
        ovf    = ((op_sel == OP_ADD) || (op_sel == OP_SUB)) && add_ovf;
        alu_op = op_sel;
    end

    // Checks across the decoder and the datapath.
    always_comb begin
        if (!$isunknown({cls_code, funct, opnd_a, opnd_b})) begin
            assert_force_add_R2: assert (!(cls_code == CLS_FORCE_ADD) || alu_op == 3'b010)
                else $error("class 00 did not select add");
            assert_force_sub_R3: assert (!(cls_code == CLS_FORCE_SUB) || alu_op == 3'b110)
                else $error("class 01 did not select subtract");
            assert_slt_zero_ext_R8: assert (!(alu_op == 3'b111) || result[DATA_W-1:1] == '0)
                else $error("compare result not zero-extended");
            assert_sub_equal_zero_R9: assert (!(alu_op == 3'b110 && opnd_a == opnd_b) || zero)
                else $error("equal operands under subtract did not raise zero");
            assert_no_overflow_R10: assert (!ovf || alu_op == 3'b010 || alu_op == 3'b110)
                else $error("overflow raised outside add or subtract");
        end
    end
endmodule

// File: tb/alu_with_decode_tb.sv
module alu_with_decode_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cls_code = 2'b00;
    logic [5:0]  funct = 6'd0;
    logic [31:0] opnd_a = 32'd0;
    logic [31:0] opnd_b = 32'd0;
    logic [2:0]  alu_op;
    logic [31:0] result;
    logic        zero;
    logic        ovf;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_with_decode u_dut (
        .cls_code (cls_code),
        .funct    (funct),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .alu_op   (alu_op),
        .result   (result),
        .zero     (zero),
        .ovf      (ovf)
    );

    // Expected operation from the requirements.
    function automatic logic [2:0] ref_op(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return 3'b010;
        if (c == 2'b01) return 3'b110;
        if (c == 2'b11) return 3'b010;
        case (f)
            6'b100000: return 3'b010;
            6'b100010: return 3'b110;
            6'b100100: return 3'b000;
            6'b100101: return 3'b001;
            6'b101010: return 3'b111;
            default:   return 3'b010;
        endcase
    endfunction

    function automatic logic [31:0] ref_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        case (op)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b110:  return a - b;
            3'b111:  return (sa < sb) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    function automatic logic ref_ovf(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint t;
        if (op == 3'b010) t = sa + sb;
        else if (op == 3'b110) t = sa - sb;
        else return 1'b0;
        return (t > 64'sd2147483647) || (t < -64'sd2147483648);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: cls=%b funct=%b a=%h b=%h actual=%h expected=%h",
                     req, what, cls_code, funct, opnd_a, opnd_b, act, exp);
        end
    endtask

    // Apply after a rising edge; sample at the falling edge.
    task automatic apply(input logic [1:0] c, input logic [5:0] f,
                         input logic [31:0] a, input logic [31:0] b, input string req);
        logic [2:0]  eop;
        logic [31:0] eres;
        @(posedge clk);
        cls_code = c; funct = f; opnd_a = a; opnd_b = b;
        @(negedge clk);
        eop  = ref_op(c, f);
        eres = ref_res(eop, a, b);
        check(req, "op", {29'd0, alu_op}, {29'd0, eop});
        check(req, "result", result, eres);
        check("R9", "zero", {31'd0, zero}, {31'd0, (eres == 32'd0)});
        check("R10", "ovf", {31'd0, ovf}, {31'd0, ref_ovf(eop, a, b)});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stimulus
        logic [5:0] fn_list [5];
        void'($urandom(32'd20240517));
        fn_list[0] = 6'b100000; fn_list[1] = 6'b100010; fn_list[2] = 6'b100100;
        fn_list[3] = 6'b100101; fn_list[4] = 6'b101010;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle inputs: add of zeros, result zero, zero flag high (R9).
        apply(2'b00, 6'd0, 32'd0, 32'd0, "R2");

        // Forced classes ignore the function field (R2, R3).
        apply(2'b00, 6'b100100, 32'h0000_00F0, 32'h0000_000F, "R2");
        apply(2'b01, 6'b100101, 32'h0000_0010, 32'h0000_0003, "R3");
        apply(2'b01, 6'b101010, 32'h1234_5678, 32'h1234_5678, "R3");

        // Function field decode (R4) and bitwise ops (R6).
        apply(2'b10, 6'b100100, 32'hF0F0_AAAA, 32'hFF00_5555, "R6");
        apply(2'b10, 6'b100101, 32'hF0F0_AAAA, 32'h0F00_5555, "R6");
        apply(2'b10, 6'b100000, 32'hFFFF_FFFF, 32'h0000_0001, "R7");
        apply(2'b10, 6'b100010, 32'h0000_0000, 32'h0000_0001, "R7");
        apply(2'b10, 6'b101010, 32'h0000_0001, 32'h0000_0002, "R4");

        // Class 11 and unlisted codes fall back to add (R5).
        apply(2'b11, 6'b100010, 32'h0000_0005, 32'h0000_0007, "R5");
        apply(2'b10, 6'b000000, 32'h0000_0005, 32'h0000_0007, "R5");
        apply(2'b10, 6'b100011, 32'h8000_0000, 32'h8000_0000, "R5");

        // Signed compare corners (R8).
        apply(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0001, "R8");
        apply(2'b10, 6'b101010, 32'h0000_0001, 32'hFFFF_FFFF, "R8");
        apply(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, "R8");
        apply(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, "R8");
        apply(2'b10, 6'b101010, 32'h4000_0000, 32'h4000_0000, "R8");

        // Overflow boundaries (R10).
        apply(2'b00, 6'd0, 32'h7FFF_FFFF, 32'h0000_0001, "R10");
        apply(2'b00, 6'd0, 32'h8000_0000, 32'hFFFF_FFFF, "R10");
        apply(2'b01, 6'd0, 32'h8000_0000, 32'h0000_0001, "R10");
        apply(2'b01, 6'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R10");
        apply(2'b01, 6'd0, 32'h0000_0000, 32'h8000_0000, "R10");
        apply(2'b10, 6'b100101, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R10");

        // Constrained random mix (R1 through R10).
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [1:0]  c;
            logic [5:0]  f;
            logic [31:0] a;
            logic [31:0] b;
            c = 2'($urandom_range(3, 0));
            if ($urandom_range(7, 0) == 0) f = 6'($urandom);
            else f = fn_list[$urandom_range(4, 0)];
            case ($urandom_range(3, 0))
                0: begin a = $urandom; b = a; end
                1: begin a = {$urandom_range(1, 0) == 1, 31'h7FFF_FFF0 + 31'($urandom_range(15, 0))}; b = $urandom; end
                default: begin a = $urandom; b = $urandom; end
            endcase
            apply(c, f, a, b, "R1");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule